// File: doc/BRIEF.md
# Serial Port Register and Interrupt Controller

This block is the bus-facing control unit of a simple byte-oriented serial port. It decodes a 256-byte window on a 32-bit bus with byte enables. It holds six configuration and status words, each with a fixed set of writable bits and a fixed reset value, and it owns one FIFO for each direction. The line side, meaning the serialiser and deserialiser that are not part of this block, moves bytes through two 8-bit valid/ready streams. One level interrupt output combines the status flags with their enable bits.

Software sends a byte by writing it into the most-significant lane of the transmit data word. It receives a byte by reading the most-significant lane of the receive data word. Two sticky flags report that the receive side holds data and that the transmit side has drained. Software clears a flag by writing 0 to it, while writing 1 leaves it as it is. Either FIFO can be flushed from the FIFO control word, but only when the flush-enable bit is set in the same word.

Top module: `sio_regbank`

## Requirements
- R1: After reset the word at offset 0x00 (line control) reads 0x40000000, the word at offset 0x14 (baud setting) reads 0x03FF0000, and the words at 0x04, 0x08, 0x0C and 0x10 read 0 until a flag sets. The interrupt is low, tx_valid is low and rx_ready is high.
- R2: A write updates only the lanes whose enable is set. bus_be[3] selects bits 31:24 (byte offset 0), down to bus_be[0], which selects bits 7:0. The stored value then keeps only the writable bits: 0xE17F0000 at offset 0x00, 0x000F0000 at 0x08, 0x001F0000 at 0x10 and 0x03FF0000 at 0x14.
- R3: The word at offset 0x04 (line status) always reads 0, and writes to it change nothing.
- R4: Flag bit 16 of the word at offset 0x0C sets when the receive FIFO was non-empty in the previous cycle. Flag bit 17 sets when the transmit FIFO was empty in the previous cycle. Both flags stay set until software clears them, and a set condition in a cycle overrides a clear written in that same cycle.
- R5: A write to offset 0x0C with bus_be[2] set leaves each of bits 18:16 at the AND of its old value and the written bit. Bit 18 is never set by hardware.
- R6: irq is high exactly when the bitwise AND of the flag word (0x0C) and the enable word (0x08) is non-zero. Bit 16 enables the receive flag and bit 17 enables the transmit flag, and irq follows the stored words with no added delay.
- R7: A write to offset 0x10 flushes the transmit FIFO when bits 16 and 18 are both 1 after the write. It flushes the receive FIFO when bits 16 and 17 are both 1 after the write. With bit 16 clear, neither FIFO is flushed.
- R8: A write to offset 0x20 with bus_be[3] set queues bits 31:24 for transmission, and a write without bus_be[3] queues nothing. Queued bytes leave on tx_data in order, one for each cycle with tx_valid and tx_ready both high.
- R9: A read of offset 0x30 with bus_be[3] set and a non-empty receive FIFO returns the oldest byte in bits 31:24, with 0 elsewhere, and removes it. Any other read of that word returns 0 and removes nothing.
- R10: Each FIFO holds FIFO_DEPTH bytes (16 by default). rx_ready is low while the receive FIFO is full, a transmit write into a full FIFO is dropped, and a read or line pop of an empty FIFO has no effect.
- R11: Bit 19 of the enable word is stored and read back but has no other effect. Offsets outside the eight defined words read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte address inside the window |
| bus_be | input | 4 | Byte-lane enables, bit 3 is bits 31:24 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Line side takes the transmit byte |
| tx_data | output | 8 | Oldest transmit byte |
| rx_valid | input | 1 | Line side offers a received byte |
| rx_ready | output | 1 | Receive FIFO can accept a byte |
| rx_data | input | 8 | Received byte |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume one bus access per cycle and that the line-side handshakes are sampled only at the rising edge. They make no assumption about how often tx_ready or rx_valid toggle. They also treat a flag as able to be cleared only by a write to the flag word whose lane 2 carries a 0 in that bit. The stimulus meets these assumptions by driving every input at the falling edge. It drives one access per cycle from the task that updates the bench's own model. It also fills the receive FIFO past its depth and starts writes while the transmit FIFO is stalled and full.

// File: rtl/sio_pkg.sv
package sio_pkg;

   localparam int unsigned ADDR_W  = 8;
   localparam int unsigned WORD_W  = 32;
   localparam int unsigned LANES   = WORD_W / 8;

   // word indices (byte offset / 4)
   localparam logic [5:0] IDX_LINE  = 6'd0;
   localparam logic [5:0] IDX_LSTAT = 6'd1;
   localparam logic [5:0] IDX_IEN   = 6'd2;
   localparam logic [5:0] IDX_ISTS  = 6'd3;
   localparam logic [5:0] IDX_FCTL  = 6'd4;
   localparam logic [5:0] IDX_BAUD  = 6'd5;
   localparam logic [5:0] IDX_TXD   = 6'd8;
   localparam logic [5:0] IDX_RXD   = 6'd12;

   localparam logic [WORD_W-1:0] LINE_MASK  = 32'hE17F_0000;
   localparam logic [WORD_W-1:0] LINE_RST   = 32'h4000_0000;
   localparam logic [WORD_W-1:0] IEN_MASK   = 32'h000F_0000;
   localparam logic [WORD_W-1:0] ISTS_MASK  = 32'h0007_0000;
   localparam logic [WORD_W-1:0] FCTL_MASK  = 32'h001F_0000;
   localparam logic [WORD_W-1:0] BAUD_MASK  = 32'h03FF_0000;
   localparam logic [WORD_W-1:0] BAUD_RST   = 32'h03FF_0000;

   localparam int unsigned FLAG_RX   = 16;
   localparam int unsigned FLAG_TX   = 17;
   localparam int unsigned FLUSH_EN  = 16;
   localparam int unsigned FLUSH_RX  = 17;
   localparam int unsigned FLUSH_TX  = 18;
   localparam int unsigned DATA_LANE = LANES - 1;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_LINE,
      SEL_LSTAT,
      SEL_IEN,
      SEL_ISTS,
      SEL_FCTL,
      SEL_BAUD,
      SEL_TXD,
      SEL_RXD
   } reg_sel_e;

   // replace the enabled lanes of old_v with those of new_v
   function automatic logic [WORD_W-1:0] lane_merge(input logic [WORD_W-1:0] old_v,
                                                    input logic [WORD_W-1:0] new_v,
                                                    input logic [LANES-1:0]  be);
      logic [WORD_W-1:0] res;
      res = old_v;
      for (int i = 0; i < int'(LANES); i++) begin
         if (be[i]) res[i*8 +: 8] = new_v[i*8 +: 8];
      end
      return res;
   endfunction

   // keep a bit of old_v in an enabled lane only where new_v is also 1
   function automatic logic [WORD_W-1:0] lane_and(input logic [WORD_W-1:0] old_v,
                                                  input logic [WORD_W-1:0] new_v,
                                                  input logic [LANES-1:0]  be);
      logic [WORD_W-1:0] res;
      res = old_v;
      for (int i = 0; i < int'(LANES); i++) begin
         if (be[i]) res[i*8 +: 8] = old_v[i*8 +: 8] & new_v[i*8 +: 8];
      end
      return res;
   endfunction

endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        flush,
   input  logic                        push,
   input  logic [DATA_W-1:0]           push_data,
   input  logic                        pop,
   output logic [DATA_W-1:0]           head,
   output logic                        empty,
   output logic                        full,
   output logic [$clog2(DEPTH+1)-1:0]  count
);

   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = $clog2(DEPTH+1);

   generate
      if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
         $error("sio_fifo: DEPTH must be a power of two of at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("sio_fifo: DATA_W must be positive");
      end
   endgenerate

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0]  rd_q, wr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              push_ok, pop_ok;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign head    = mem_q[rd_q];
   assign count   = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_ok) wr_q <= wr_q + 1'b1;
         if (pop_ok)  rd_q <= rd_q + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem_q[wr_q] <= push_data;
   end

   p_full_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> $stable(cnt_q));

   p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);

endmodule

// File: rtl/sio_bus_decode.sv
module sio_bus_decode
   import sio_pkg::*;
(
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);

   logic [ADDR_W-3:0] word_idx;
   assign word_idx = addr[ADDR_W-1:2];

   always_comb begin
      case (word_idx)
         IDX_LINE:  sel = SEL_LINE;
         IDX_LSTAT: sel = SEL_LSTAT;
         IDX_IEN:   sel = SEL_IEN;
         IDX_ISTS:  sel = SEL_ISTS;
         IDX_FCTL:  sel = SEL_FCTL;
         IDX_BAUD:  sel = SEL_BAUD;
         IDX_TXD:   sel = SEL_TXD;
         IDX_RXD:   sel = SEL_RXD;
         default:   sel = SEL_NONE;
      endcase
   end

endmodule

// File: rtl/sio_irq_unit.sv
module sio_irq_unit
   import sio_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ien_wr,
   input  logic              ists_wr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [LANES-1:0]  be,
   input  logic              rx_nonempty,
   input  logic              tx_empty,
   output logic [WORD_W-1:0] ien_q,
   output logic [WORD_W-1:0] ists_q,
   output logic              irq
);

   logic [WORD_W-1:0] ien_d, ists_d;
   localparam int unsigned FLAG_LANE = FLAG_RX / 8;

   always_comb begin
      ien_d = ien_q;
      if (ien_wr) ien_d = lane_merge(ien_q, wdata, be) & IEN_MASK;

      ists_d = ists_q;
      if (ists_wr) ists_d = lane_and(ists_q, wdata, be) & ISTS_MASK;
      // hardware set conditions take priority over a clear
      if (rx_nonempty) ists_d[FLAG_RX] = 1'b1;
      if (tx_empty)    ists_d[FLAG_TX] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ien_q  <= '0;
         ists_q <= '0;
      end else begin
         ien_q  <= ien_d;
         ists_q <= ists_d;
      end
   end

   assign irq = |(ists_q & ien_q);

   p_rx_flag_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_nonempty |=> ists_q[FLAG_RX]);

   p_tx_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ists_q[FLAG_TX] && !(ists_wr && be[FLAG_LANE] && !wdata[FLAG_TX])) |=> ists_q[FLAG_TX]);

   p_clear_needs_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ists_q[FLAG_RX] && !ists_wr) |=> ists_q[FLAG_RX]);

endmodule

// File: rtl/sio_regbank.sv
module sio_regbank
   import sio_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_valid,
   input  logic                 bus_write,
   input  logic [7:0]           bus_addr,
   input  logic [3:0]           bus_be,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   output logic                 tx_valid,
   input  logic                 tx_ready,
   output logic [7:0]           tx_data,
   input  logic                 rx_valid,
   output logic                 rx_ready,
   input  logic [7:0]           rx_data,
   output logic                 irq
);

   localparam int unsigned CNT_W = $clog2(FIFO_DEPTH+1);
   localparam int unsigned LANE_LO = DATA_LANE * 8;

   generate
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("sio_regbank: FIFO_DEPTH must be at least 2");
      end
   endgenerate

   reg_sel_e          sel;
   logic              wr, rd;
   logic [WORD_W-1:0] line_q, fctl_q, baud_q, fctl_d;
   logic [WORD_W-1:0] ien_q, ists_q;
   logic              flush_tx, flush_rx;
   logic              tx_push, tx_pop, rx_push, rx_pop;
   logic              tx_empty, tx_full, rx_empty, rx_full;
   logic [7:0]        rx_head;
   logic [CNT_W-1:0]  tx_count, rx_count;

   sio_bus_decode u_decode (
      .addr (bus_addr),
      .sel  (sel)
   );

   assign wr = bus_valid && bus_write;
   assign rd = bus_valid && !bus_write;

   // configuration words
   assign fctl_d = lane_merge(fctl_q, bus_wdata, bus_be) & FCTL_MASK;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_q <= LINE_RST;
         fctl_q <= '0;
         baud_q <= BAUD_RST;
      end else if (wr) begin
         if (sel == SEL_LINE) line_q <= lane_merge(line_q, bus_wdata, bus_be) & LINE_MASK;
         if (sel == SEL_FCTL) fctl_q <= fctl_d;
         if (sel == SEL_BAUD) baud_q <= lane_merge(baud_q, bus_wdata, bus_be) & BAUD_MASK;
      end
   end

   assign flush_tx = wr && (sel == SEL_FCTL) && fctl_d[FLUSH_EN] && fctl_d[FLUSH_TX];
   assign flush_rx = wr && (sel == SEL_FCTL) && fctl_d[FLUSH_EN] && fctl_d[FLUSH_RX];

   // flags and interrupt
   sio_irq_unit u_irq (
      .clk         (clk),
      .rst_n       (rst_n),
      .ien_wr      (wr && (sel == SEL_IEN)),
      .ists_wr     (wr && (sel == SEL_ISTS)),
      .wdata       (bus_wdata),
      .be          (bus_be),
      .rx_nonempty (!rx_empty),
      .tx_empty    (tx_empty),
      .ien_q       (ien_q),
      .ists_q      (ists_q),
      .irq         (irq)
   );

   // transmit path
   assign tx_push  = wr && (sel == SEL_TXD) && bus_be[DATA_LANE];
   assign tx_valid = !tx_empty;
   assign tx_pop   = tx_valid && tx_ready;

   sio_fifo #(.DATA_W(8), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush_tx),
      .push      (tx_push),
      .push_data (bus_wdata[LANE_LO +: 8]),
      .pop       (tx_pop),
      .head      (tx_data),
      .empty     (tx_empty),
      .full      (tx_full),
      .count     (tx_count)
   );

   // receive path
   assign rx_ready = !rx_full;
   assign rx_push  = rx_valid && rx_ready;
   assign rx_pop   = rd && (sel == SEL_RXD) && bus_be[DATA_LANE];

   sio_fifo #(.DATA_W(8), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush_rx),
      .push      (rx_push),
      .push_data (rx_data),
      .pop       (rx_pop),
      .head      (rx_head),
      .empty     (rx_empty),
      .full      (rx_full),
      .count     (rx_count)
   );

   // read mux
   always_comb begin
      bus_rdata = '0;
      case (sel)
         SEL_LINE: bus_rdata = line_q;
         SEL_IEN:  bus_rdata = ien_q;
         SEL_ISTS: bus_rdata = ists_q;
         SEL_FCTL: bus_rdata = fctl_q;
         SEL_BAUD: bus_rdata = baud_q;
         SEL_RXD:  if (bus_be[DATA_LANE] && !rx_empty) bus_rdata[LANE_LO +: 8] = rx_head;
         default:  bus_rdata = '0;
      endcase
   end

   p_txd_lane_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && (sel == SEL_TXD) && !bus_be[DATA_LANE] && !tx_pop) |=> $stable(tx_count));

   p_rxd_no_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && (sel == SEL_RXD) && !bus_be[DATA_LANE] && !rx_push) |=> $stable(rx_count));

endmodule

// File: tb/sio_regbank_bench.sv
module sio_regbank_bench;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 16;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_valid, bus_write;
   logic [7:0]  bus_addr;
   logic [3:0]  bus_be;
   logic [31:0] bus_wdata, bus_rdata;
   logic        tx_valid, tx_ready;
   logic [7:0]  tx_data;
   logic        rx_valid, rx_ready;
   logic [7:0]  rx_data;
   logic        irq;

   always #(CLK_PERIOD/2) clk = ~clk;

   sio_regbank #(.FIFO_DEPTH(DEPTH)) u_sio_regbank (
      .clk(clk), .rst_n(rst_n),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
      .irq(irq)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 0;

   // behavioural model
   logic [31:0] m_line, m_ien, m_ists, m_fctl, m_baud;
   logic [7:0]  txq[$];
   logic [7:0]  rxq[$];

   // line-side drive used by every step
   logic       g_txr = 1'b0;
   logic       g_rxv = 1'b0;
   logic [7:0] g_rxd = 8'h00;

   function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
      logic [31:0] r = o;
      for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = n[i*8 +: 8];
      return r;
   endfunction

   task automatic model_reset();
      m_line = 32'h4000_0000; m_ien = 0; m_ists = 0; m_fctl = 0; m_baud = 32'h03FF_0000;
      txq.delete(); rxq.delete();
   endtask

   task automatic check1(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // one bus cycle: drive, compare against the model, advance the model
   task automatic step(input logic v, input logic w, input logic [7:0] a, input logic [3:0] be,
                       input logic [31:0] d, input string tag);
      logic [31:0] e_rd, n_ists;
      logic [5:0]  idx;
      int          bad0, tx_sz, rx_sz;
      bit          ftx, frx, txpop, txpush, rxpop, rxpush;
      bus_valid = v; bus_write = w; bus_addr = a; bus_be = be; bus_wdata = d;
      tx_ready = g_txr; rx_valid = g_rxv; rx_data = g_rxd;
      #2;
      idx   = a[7:2];
      tx_sz = txq.size(); rx_sz = rxq.size();
      case (idx)
         6'd0:  e_rd = m_line;
         6'd2:  e_rd = m_ien;
         6'd3:  e_rd = m_ists;
         6'd4:  e_rd = m_fctl;
         6'd5:  e_rd = m_baud;
         6'd12: e_rd = (be[3] && rx_sz > 0) ? {rxq[0], 24'h0} : 32'h0;
         default: e_rd = 32'h0;
      endcase
      bad0 = n_bad;
      check1(tag, "irq", {31'h0, irq}, {31'h0, |(m_ists & m_ien)});
      check1(tag, "tx_valid", {31'h0, tx_valid}, {31'h0, tx_sz > 0});
      if (tx_sz > 0) check1(tag, "tx_data", {24'h0, tx_data}, {24'h0, txq[0]});
      check1(tag, "rx_ready", {31'h0, rx_ready}, {31'h0, rx_sz < DEPTH});
      if (v && !w) check1(tag, "rdata", bus_rdata, e_rd);
      n_vec++;
      if (n_bad > bad0 + 1) n_bad = bad0 + 1;
      // next state from pre-edge values
      n_ists = m_ists;
      ftx = 0; frx = 0;
      if (v && w) begin
         case (idx)
            6'd0: m_line = merge(m_line, d, be) & 32'hE17F_0000;
            6'd2: m_ien  = merge(m_ien, d, be) & 32'h000F_0000;
            6'd3: begin
               for (int i = 0; i < 4; i++) if (be[i]) n_ists[i*8 +: 8] = m_ists[i*8 +: 8] & d[i*8 +: 8];
               n_ists &= 32'h0007_0000;
            end
            6'd4: begin
               m_fctl = merge(m_fctl, d, be) & 32'h001F_0000;
               ftx = m_fctl[16] && m_fctl[18];
               frx = m_fctl[16] && m_fctl[17];
            end
            6'd5: m_baud = merge(m_baud, d, be) & 32'h03FF_0000;
            default: ;
         endcase
      end
      if (rx_sz > 0)  n_ists[16] = 1'b1;
      if (tx_sz == 0) n_ists[17] = 1'b1;
      m_ists = n_ists;
      txpop  = (tx_sz > 0) && g_txr;
      txpush = v && w && idx == 6'd8 && be[3] && tx_sz < DEPTH;
      rxpop  = v && !w && idx == 6'd12 && be[3] && rx_sz > 0;
      rxpush = g_rxv && rx_sz < DEPTH;
      if (txpop)  void'(txq.pop_front());
      if (txpush) txq.push_back(d[31:24]);
      if (ftx)    txq.delete();
      if (rxpop)  void'(rxq.pop_front());
      if (rxpush) rxq.push_back(g_rxd);
      if (frx)    rxq.delete();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr_(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d, input string tag);
      step(1'b1, 1'b1, a, be, d, tag);
   endtask
   task automatic rd_(input logic [7:0] a, input logic [3:0] be, input string tag);
      step(1'b1, 1'b0, a, be, 32'h0, tag);
   endtask
   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h0, 4'h0, 32'h0, tag);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      rst_n = 1'b0; bus_valid = 0; bus_write = 0; bus_addr = 0; bus_be = 0; bus_wdata = 0;
      tx_ready = 0; rx_valid = 0; rx_data = 0;
      model_reset();
      repeat (3) @(negedge clk);
      // R1: outputs in reset
      n_vec++;
      if (irq !== 1'b0 || tx_valid !== 1'b0 || rx_ready !== 1'b1) begin
         n_bad++;
         $display("FAIL R1 reset outputs: actual %b%b%b expected 001", irq, tx_valid, rx_ready);
      end
      rst_n = 1'b1;

      // R1: reset values
      rd_(8'h00, 4'hF, "R1"); rd_(8'h14, 4'hF, "R1"); rd_(8'h08, 4'hF, "R1");
      rd_(8'h10, 4'hF, "R1"); rd_(8'h04, 4'hF, "R3");

      // R2: masked writes and lanes
      wr_(8'h00, 4'hF, 32'hFFFF_FFFF, "R2"); rd_(8'h00, 4'hF, "R2");
      wr_(8'h00, 4'h8, 32'h0000_0000, "R2"); rd_(8'h00, 4'hF, "R2");
      wr_(8'h14, 4'h4, 32'hFFAA_FFFF, "R2"); rd_(8'h14, 4'hF, "R2");
      wr_(8'h14, 4'h8, 32'h0100_0000, "R2"); rd_(8'h14, 4'hF, "R2");
      wr_(8'h10, 4'h3, 32'hFFFF_FFFF, "R2"); rd_(8'h10, 4'hF, "R2");
      // R3: line status read-only
      wr_(8'h04, 4'hF, 32'hFFFF_FFFF, "R3"); rd_(8'h04, 4'hF, "R3");
      // R11: DMA enable stored, undefined offsets
      wr_(8'h08, 4'h4, 32'h0008_0000, "R11"); rd_(8'h08, 4'hF, "R11");
      wr_(8'h18, 4'hF, 32'hFFFF_FFFF, "R11"); rd_(8'h18, 4'hF, "R11");
      wr_(8'hFC, 4'hF, 32'hFFFF_FFFF, "R11"); rd_(8'hFC, 4'hF, "R11");
      rd_(8'h20, 4'hF, "R11");

      // R4/R6: tx flag set while empty, clear loses to set
      rd_(8'h0C, 4'hF, "R4");
      wr_(8'h08, 4'h4, 32'h0002_0000, "R6"); idle(1, "R6");
      wr_(8'h0C, 4'h4, 32'h0000_0000, "R4"); rd_(8'h0C, 4'hF, "R4");
      // R8: queue bytes with line stalled, clear flag, irq drops
      wr_(8'h20, 4'h8, 32'hA1_000000, "R8");
      wr_(8'h20, 4'h7, 32'hB2_FFFFFF, "R8");
      wr_(8'h21, 4'h8, 32'hC3_000000, "R8");
      wr_(8'h0C, 4'h4, 32'h0000_0000, "R5"); idle(2, "R6");
      wr_(8'h0C, 4'h8, 32'h0000_0000, "R5"); rd_(8'h0C, 4'hF, "R5");
      g_txr = 1'b1; idle(4, "R8"); g_txr = 1'b0;
      rd_(8'h0C, 4'hF, "R4");
      // R10: tx overflow
      for (int i = 0; i < DEPTH + 3; i++) wr_(8'h20, 4'h8, {8'(i + 8'h40), 24'h0}, "R10");
      g_txr = 1'b1; idle(DEPTH + 2, "R10"); g_txr = 1'b0;

      // R9/R10: receive fill past depth
      wr_(8'h08, 4'h4, 32'h0001_0000, "R6");
      wr_(8'h0C, 4'h4, 32'h0000_0000, "R5");
      rd_(8'h30, 4'h8, "R9");
      g_rxv = 1'b1;
      for (int i = 0; i < DEPTH + 4; i++) begin g_rxd = 8'(8'h60 + i); idle(1, "R10"); end
      g_rxv = 1'b0;
      rd_(8'h30, 4'h7, "R9"); rd_(8'h30, 4'h8, "R9"); rd_(8'h30, 4'hF, "R9");
      wr_(8'h0C, 4'h4, 32'h0000_0000, "R4"); rd_(8'h0C, 4'hF, "R4");
      // R7: flush without and with enable
      wr_(8'h10, 4'h4, 32'h0006_0000, "R7"); rd_(8'h30, 4'h8, "R7");
      wr_(8'h10, 4'h4, 32'h0003_0000, "R7"); rd_(8'h30, 4'h8, "R7");
      wr_(8'h20, 4'h8, 32'h5500_0000, "R7"); wr_(8'h20, 4'h8, 32'h6600_0000, "R7");
      wr_(8'h10, 4'h4, 32'h0005_0000, "R7"); idle(2, "R7");
      for (int i = 0; i < DEPTH + 2; i++) rd_(8'h30, 4'h8, "R10");
      wr_(8'h10, 4'h4, 32'h0000_0000, "R7");

      // mixed traffic
      seed = 32'h1234_5678;
      for (int n = 0; n < 600; n++) begin
         logic [7:0] a;
         seed = seed * 32'd1103515245 + 32'd12345;
         g_txr = seed[20]; g_rxv = seed[21] & seed[22]; g_rxd = seed[30:23];
         a = {seed[9] ? 4'h3 : {1'b0, seed[12:10]}, seed[14:13], 2'b00};
         if (a == 8'h10 && seed[15]) a = 8'h20;
         case (seed[17:16])
            2'd0: wr_(a, seed[27:24], {seed[31:16], seed[15:0]}, "R8");
            2'd1: wr_(8'h20, 4'h8, {seed[31:24], 24'h0}, "R8");
            default: rd_(a, seed[27:24] | 4'h8, "R9");
         endcase
      end
      g_txr = 0; g_rxv = 0;
      idle(2, "R6");

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule